// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A synchronous single-port static memory, 36 bits wide and split into four 9-bit bytes, with a parameterised depth. One command is sampled on each rising clock edge while the chip select is high. The command either loads a fresh address or continues a four-word burst from an internal 2-bit counter. The counter steps in either linear or interleaved order. A command is a write when the global write is high, or when the byte-write enable is high together with at least one byte select. Every other selected cycle is a read.

Read data leaves through one of two paths, picked by a static mode input. The flow-through path drives the array output straight onto the bus. The pipelined path adds an output register, which costs one more cycle. Turning the bus off after a deselect is staged one register less than a read. This means the drivers go quiet on the edge that captures the deselect, in both modes. The bus drive-enable also follows the active-low output enable and the sleep input at once, without waiting for a clock edge. Sleep blocks all commands and keeps the stored contents.

Top module: `sync_burst_ram`

## Requirements
- R1: While reset is asserted, and after it is released with no command issued, `dq_oe` is low.
- R2: A selected cycle with `gw` high writes all four bytes of `wdata`, whatever `bwe` and `bsel` are.
- R3: With `gw` low, a cycle with `bwe` high writes only the bytes whose `bsel` bit is high. Byte i occupies bits 9i+8 down to 9i. If `bwe` is low, or if no `bsel` bit is high, the cycle is a read and the stored word is unchanged.
- R4: With `pipe_mode` low (flow-through), data for a read sampled at edge k is on `dq` with `dq_oe` high in the cycle that follows edge k.
- R5: With `pipe_mode` high (pipelined), data for a read sampled at edge k appears after edge k+1. Nothing is driven between edge k and edge k+1 unless an earlier read is completing.
- R6: An edge that samples `cs` low turns `dq_oe` off right after that edge, in either mode. In pipelined mode this also drops the read sampled one edge earlier.
- R7: `oe_n` high forces `dq_oe` low immediately, with no clock edge. Lowering `oe_n` again restores the drive of a read that is still valid.
- R8: `sleep` high forces `dq_oe` low immediately and blocks reads and writes, and the memory contents are kept. A command sampled at the first edge after `sleep` falls is executed normally.
- R9: A read of an address on the cycle right after a write to that address returns the newly written word.
- R10: `ld` high takes the address from `addr`. `ld` low continues the burst from the last loaded address, with offsets 1, 2, 3, 0 from the loaded word. With `burst_lin` high the next address's low two bits are the base's low two bits plus the offset, mod 4. With `burst_lin` low they are the base's low two bits XOR the offset. The upper bits stay at the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cs | input | 1 | Chip select; high makes the cycle a command |
| ld | input | 1 | High loads `addr`; low continues the burst |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| gw | input | 1 | Global write, all bytes |
| bwe | input | 1 | Byte-write enable |
| bsel | input | 4 | Per-byte write selects, bit i for byte i |
| wdata | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous low-power request |
| pipe_mode | input | 1 | 1 pipelined read path, 0 flow-through |
| dq | output | 36 | Read data |
| dq_oe | output | 1 | Bus drive-enable for `dq` |

## Verification
The hardest case to reach from the ports is a pipelined read whose output stage is already loaded while the next edge samples a deselect. The data sits in the output register, but the bus must stay quiet. The stimulus reaches this state by running a pipelined linear burst until two words have been driven, then dropping `cs` in mid-burst. The bench then requires `dq_oe` to be low right after that edge. Sleep gets similar handling: a write is held active across several sleeping edges, and a read issued on the first edge after wake-up shows that the stored word was not changed.

// File: rtl/sync_burst_ram.sv
`timescale 1ns/1ps
module sync_burst_ram #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              ld,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw,
  input  logic              bwe,
  input  logic [BYTES-1:0]  bsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              pipe_mode,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base_q, rd_addr_q;
  logic [1:0]        cnt_q;
  logic              rd_q, pv_q, sel_q;
  logic [DATA_W-1:0] dout_q;

  wire [1:0]        cnt_n = cnt_q + 2'd1;
  wire [1:0]        lo    = burst_lin ? base_q[1:0] + cnt_n : base_q[1:0] ^ cnt_n;
  wire [ADDR_W-1:0] eff   = ld ? addr : {base_q[ADDR_W-1:2], lo};
  wire              cmd   = cs & ~sleep;
  wire              wr    = cmd & (gw | (bwe & |bsel));
  wire              rd    = cmd & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      cnt_q     <= '0;
      rd_addr_q <= '0;
      rd_q      <= 1'b0;
      pv_q      <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      sel_q <= cmd;
      rd_q  <= rd;
      pv_q  <= rd_q;
      if (cmd) begin
        if (ld) begin
          base_q <= addr;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_n;
        end
      end
      if (rd) rd_addr_q <= eff;
    end
  end

  always_ff @(posedge clk) begin
    if (wr)
      for (int i = 0; i < BYTES; i++)
        if (gw | (bwe & bsel[i]))
          mem[eff][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
  end

  wire [DATA_W-1:0] ft_data = mem[rd_addr_q];

  always_ff @(posedge clk) begin
    if (rd_q) dout_q <= ft_data;
  end

  wire valid = pipe_mode ? (pv_q & sel_q) : rd_q;
  assign dq    = pipe_mode ? dout_q : ft_data;
  assign dq_oe = valid & ~oe_n & ~sleep;

  p_desel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dq_oe);

  p_ft_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !pipe_mode) |=> (dq_oe || oe_n || sleep || pipe_mode));

  p_pipe_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && pipe_mode) ##1 cmd |=> (dq_oe || oe_n || sleep || !pipe_mode));

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!dq_oe || !sleep));

endmodule

// File: tb/sim_sync_burst_ram.sv
`timescale 1ns/1ps
module sim_sync_burst_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, ld = 0, burst_lin = 1, gw = 0, bwe = 0;
  logic [7:0]  addr = '0;
  logic [3:0]  bsel = '0;
  logic [35:0] wdata = '0;
  logic        oe_n = 0, sleep = 0, pipe_mode = 1;
  logic [35:0] dq;
  logic        dq_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_burst_ram u0 (.clk, .rst_n, .cs, .ld, .burst_lin, .addr, .gw, .bwe,
                     .bsel, .wdata, .oe_n, .sleep, .pipe_mode, .dq, .dq_oe);

  // {gw, bwe, bsel, addr, expected word}; target preset to 0, written with all ones
  localparam logic [49:0] VEC [7] = '{
    {1'b1, 1'b0, 4'h0, 8'h10, 36'hFFFFFFFFF},
    {1'b1, 1'b1, 4'h0, 8'h11, 36'hFFFFFFFFF},
    {1'b0, 1'b1, 4'h1, 8'h12, 36'h0000001FF},
    {1'b0, 1'b1, 4'hA, 8'h13, 36'hFF803FE00},
    {1'b0, 1'b1, 4'h0, 8'h14, 36'h000000000},
    {1'b0, 1'b0, 4'hF, 8'h15, 36'h000000000},
    {1'b0, 1'b1, 4'h6, 8'h16, 36'h007FFFE00}
  };

  task automatic chk_bit(string r, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s dq_oe actual %b expected %b", r, a, e);
    end
  endtask

  task automatic chk_dat(string r, logic [35:0] a, logic [35:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s dq actual %h expected %h", r, a, e);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    cs = 0; ld = 0; gw = 0; bwe = 0; bsel = '0;
  endtask

  task automatic wr_all(logic [7:0] a, logic [35:0] d);
    cs = 1; ld = 1; gw = 1; bwe = 0; bsel = '0; addr = a; wdata = d;
    tick;
    idle;
  endtask

  task automatic rd_at(logic [7:0] a);
    cs = 1; ld = 1; gw = 0; bwe = 0; bsel = '0; addr = a;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); tick;
    chk_bit("R1 in reset", dq_oe, 1'b0);
    rst_n = 1; tick;
    chk_bit("R1 after reset", dq_oe, 1'b0);

    // R2/R3 write masking table, flow-through reads
    pipe_mode = 0; tick;
    for (int i = 0; i < 7; i++) begin
      wr_all(VEC[i][43:36], 36'h0);
      cs = 1; ld = 1; gw = VEC[i][49]; bwe = VEC[i][48]; bsel = VEC[i][47:44];
      addr = VEC[i][43:36]; wdata = 36'hFFFFFFFFF;
      tick;
      rd_at(VEC[i][43:36]);
      tick;
      chk_bit("R2/R3 table read drive", dq_oe, 1'b1);
      chk_dat("R2/R3 table word", dq, VEC[i][35:0]);
      idle; tick;
    end

    // burst data at 0x20..0x23
    for (int k = 0; k < 4; k++) wr_all(8'h20 + 8'(k), 36'hA00 + 36'(k));

    // R10 linear, R4 flow-through
    burst_lin = 1; rd_at(8'h21); tick;
    chk_bit("R4 ft first word", dq_oe, 1'b1);
    chk_dat("R10 lin 0", dq, 36'hA01);
    ld = 0; tick; chk_dat("R10 lin 1", dq, 36'hA02);
    tick; chk_dat("R10 lin 2", dq, 36'hA03);
    tick; chk_dat("R10 lin wrap", dq, 36'hA00);
    idle; tick;
    chk_bit("R6 ft deselect", dq_oe, 1'b0);

    // R10 interleaved
    burst_lin = 0; rd_at(8'h21); tick;
    chk_dat("R10 ilv 0", dq, 36'hA01);
    ld = 0; tick; chk_dat("R10 ilv 1", dq, 36'hA00);
    tick; chk_dat("R10 ilv 2", dq, 36'hA03);
    tick; chk_dat("R10 ilv 3", dq, 36'hA02);
    idle; tick;

    // R5 pipelined 3-1-1-1, R6 deselect drops in-flight word
    pipe_mode = 1; burst_lin = 1; tick;
    rd_at(8'h20); tick;
    chk_bit("R5 pipe no early data", dq_oe, 1'b0);
    ld = 0; tick;
    chk_bit("R5 pipe first drive", dq_oe, 1'b1);
    chk_dat("R5 pipe word 0", dq, 36'hA00);
    tick;
    chk_dat("R5 pipe word 1", dq, 36'hA01);
    idle; tick;
    chk_bit("R6 pipe deselect", dq_oe, 1'b0);
    tick;

    // R9 write then read next cycle
    pipe_mode = 0; tick;
    cs = 1; ld = 1; gw = 1; addr = 8'h30; wdata = 36'h5A5A5A5A5;
    tick;
    rd_at(8'h30); tick;
    chk_bit("R9 drive", dq_oe, 1'b1);
    chk_dat("R9 new data", dq, 36'h5A5A5A5A5);

    // R7 asynchronous output enable
    oe_n = 1; #1;
    chk_bit("R7 oe_n high", dq_oe, 1'b0);
    oe_n = 0; #1;
    chk_bit("R7 oe_n low", dq_oe, 1'b1);

    // R8 sleep
    sleep = 1; #1;
    chk_bit("R8 sleep async off", dq_oe, 1'b0);
    cs = 1; ld = 1; gw = 1; addr = 8'h10; wdata = 36'h0;
    tick; tick;
    chk_bit("R8 sleep stays off", dq_oe, 1'b0);
    sleep = 0;
    rd_at(8'h10); tick;
    chk_bit("R8 resume drive", dq_oe, 1'b1);
    chk_dat("R8 contents kept", dq, 36'hFFFFFFFFF);
    idle; tick;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule